// File: doc/BRIEF.md
# Interleaved DRAM Refresh Scheduler

This block sits in a memory controller and produces the periodic refresh traffic for a 32-bank DRAM. A free-running timer supplies ticks. Every fixed number of ticks one refresh becomes owed. The block settles what it owes by issuing a broadcast refresh-activate to one bank, and then a broadcast refresh-precharge to the same bank once the row-active time has passed. It walks the banks in a fixed order that never visits two adjacent banks one after the other.

While a refreshed bank is open, the block marks it as locked. It also publishes a per-bank activate hold, so that the controller's ordinary activates respect the activate-to-activate spacing: a short spacing for unrelated banks, and the full row cycle for the refreshed bank and its neighbours.

The block also manages the hand-off to the device's own self-refresh. On a request it finishes the current pass through the bank order and then reports that the device may enter low power. When the controller signals that low power has ended, the block refreshes all 32 banks once, as a burst. It reports an error if the burst window runs out before the burst is done. After that it resumes normal paced refresh from the start of the order.

Top module: `refresh_sched`

## Requirements
- R1: `cmd_sel` is 2'b11, meaning both device-select flags and therefore a broadcast, in every cycle where `cmd_valid` is high, and 2'b00 otherwise.
- R2: In normal mode, every T_INT ticks one refresh becomes owed. The owed count saturates at 2^PEND_W-1. A refresh-activate is presented only while the count is non-zero, and each accepted refresh-activate reduces it by one.
- R3: A command is accepted when `cmd_valid` and `cmd_ready` are both high. `cmd_pre`=0 marks a refresh-activate and `cmd_pre`=1 marks a refresh-precharge. The precharge to the same bank is presented exactly T_RAS cycles after the cycle in which its activate was accepted. A presented command keeps its bank and kind until it is accepted.
- R4: `bank_locked[b]` is high from the cycle after the refresh-activate of bank b is accepted, through the cycle in which its precharge is accepted.
- R5: Let d be the number of cycles since the last accepted refresh-activate, to bank L. `act_hold[b]` is high when bank b is locked, or when d < T_RR, or when d < T_RC and b is L, L-1 or L+1.
- R6: Banks are refreshed in the order 12,10,5,3,0,14,9,7,4,2,13,11,8,6,1,15, followed by the same 16 values plus 16, repeating after bank 31.
- R7: A `lp_req` pulse in normal mode starts draining. In that mode refreshes continue without waiting for owed count until the pass has finished with bank 31. `lp_ack` then stays high, and no commands are issued until `lp_exit`. `lp_req` has no effect outside normal mode, and `lp_exit` has no effect outside the acknowledged state.
- R8: `lp_exit` starts a burst that refreshes all 32 banks back to back, beginning at bank 12 and ending at bank 31. `burst_active` is high while the burst lasts. The block then returns to normal mode with no refresh owed.
- R9: `burst_err` becomes high, and stays high until reset, when T_BURST cycles have passed since the burst began and the burst is still running.
- R10: During reset no command is valid, and `lp_ack`, `burst_active`, `burst_err`, `bank_locked` and `act_hold` are all low.
- R11: At most one refresh is open at a time: no refresh-activate is presented while any bank is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Refresh timer tick |
| cmd_ready | input | 1 | Command path accepts the presented command |
| lp_req | input | 1 | Request to hand the device to self-refresh |
| lp_exit | input | 1 | Low power has ended and the restricted bus interval is over |
| cmd_valid | output | 1 | A refresh command is presented |
| cmd_pre | output | 1 | 0 = refresh-activate, 1 = refresh-precharge |
| cmd_bank | output | 5 | Target bank |
| cmd_sel | output | 2 | Device-select flags, 2'b11 for broadcast |
| bank_locked | output | 32 | Bank is open for refresh; no activate or precharge to it |
| act_hold | output | 32 | Ordinary activate to the bank must wait |
| lp_ack | output | 1 | Device may be placed in self-refresh |
| burst_active | output | 1 | Post-low-power catch-up burst in progress |
| burst_err | output | 1 | Burst window expired before all banks were refreshed |

## Verification
The embedded assertions check the following on every cycle:
- a stalled command stays unchanged until it is accepted;
- a precharge only ever targets a locked bank;
- an activate is never presented while another bank is open;
- a just-refreshed bank is held against activates;
- the acknowledged low-power state stays silent;
- the error flag is sticky.

Other properties can only be shown by the bench's scenarios, which compare against a cycle-timed reference model. These are:
- the pacing and saturation of owed refreshes;
- the exact T_RAS spacing under back-pressure;
- the bank order and its wrap;
- the drain to bank 31;
- a clean burst that meets its window;
- a throttled burst that misses it.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int T_INT   = 8,
  parameter int T_RAS   = 4,
  parameter int T_RR    = 2,
  parameter int T_RC    = 7,
  parameter int T_BURST = 256,
  parameter int PEND_W  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cmd_ready,
  input  logic        lp_req,
  input  logic        lp_exit,
  output logic        cmd_valid,
  output logic        cmd_pre,
  output logic [4:0]  cmd_bank,
  output logic [1:0]  cmd_sel,
  output logic [31:0] bank_locked,
  output logic [31:0] act_hold,
  output logic        lp_ack,
  output logic        burst_active,
  output logic        burst_err
);
  localparam int TW = $clog2(T_INT + 1);
  localparam int RW = $clog2(T_RAS + 1);
  localparam int SW = $clog2(T_RC + 1);
  localparam int WW = $clog2(T_BURST + 1);
  localparam logic [PEND_W-1:0] PMAX = '1;

  typedef enum logic [1:0] {M_NORM, M_DRAIN, M_SELF, M_BURST} mode_t;
  typedef enum logic [1:0] {P_IDLE, P_ACT, P_RAS, P_PRE} phase_t;

  mode_t             mode;
  phase_t            phase;
  logic [4:0]        idx, lastb;
  logic [PEND_W-1:0] pend;
  logic [TW-1:0]     tcnt;
  logic [RW-1:0]     rcnt;
  logic [SW-1:0]     since;
  logic [WW-1:0]     wcnt;

  function automatic logic [4:0] seq_bank(input logic [4:0] i);
    logic [3:0] lo;
    case (i[3:0])
      4'd0:  lo = 4'd12;  4'd1:  lo = 4'd10;  4'd2:  lo = 4'd5;   4'd3:  lo = 4'd3;
      4'd4:  lo = 4'd0;   4'd5:  lo = 4'd14;  4'd6:  lo = 4'd9;   4'd7:  lo = 4'd7;
      4'd8:  lo = 4'd4;   4'd9:  lo = 4'd2;   4'd10: lo = 4'd13;  4'd11: lo = 4'd11;
      4'd12: lo = 4'd8;   4'd13: lo = 4'd6;   4'd14: lo = 4'd1;   default: lo = 4'd15;
    endcase
    return {i[4], lo};
  endfunction

  assign cmd_valid    = (phase == P_ACT) || (phase == P_PRE);
  assign cmd_pre      = (phase == P_PRE);
  assign cmd_bank     = seq_bank(idx);
  assign cmd_sel      = cmd_valid ? 2'b11 : 2'b00;
  assign lp_ack       = (mode == M_SELF);
  assign burst_active = (mode == M_BURST);

  wire act_acc  = cmd_valid && cmd_ready && !cmd_pre;
  wire pre_acc  = cmd_valid && cmd_ready && cmd_pre;
  wire quiet    = (mode == M_SELF) || (mode == M_BURST);
  wire tick_due = tick && (tcnt == TW'(T_INT - 1));
  wire open_b   = (phase == P_RAS) || (phase == P_PRE);
  wire start    = ((mode == M_NORM) && (pend != '0)) ||
                  ((mode == M_DRAIN) && (idx != 5'd0)) || (mode == M_BURST);
  wire hold_rr  = since < SW'(T_RR);
  wire hold_rc  = since < SW'(T_RC);

  for (genvar b = 0; b < 32; b++) begin : g_bank
    wire adj = ({1'b0, lastb} == 6'(b)) || ({1'b0, lastb} == 6'(b + 1)) ||
               ({1'b0, lastb} == 6'(b - 1));
    assign bank_locked[b] = open_b && (cmd_bank == 5'(b));
    assign act_hold[b]    = bank_locked[b] || hold_rr || (adj && hold_rc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      pend <= '0;
    end else if (quiet) begin
      tcnt <= '0;
      pend <= '0;
    end else begin
      if (tick) tcnt <= tick_due ? '0 : tcnt + 1'b1;
      pend <= pend + PEND_W'(tick_due && pend != PMAX) - PEND_W'(act_acc && pend != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      idx   <= '0;
      rcnt  <= '0;
    end else begin
      case (phase)
        P_IDLE: if (start && !(mode == M_SELF)) phase <= P_ACT;
        P_ACT:  if (act_acc) begin
                  phase <= P_RAS;
                  rcnt  <= RW'(T_RAS - 1);
                end
        P_RAS:  if (rcnt == RW'(1)) phase <= P_PRE;
                else rcnt <= rcnt - 1'b1;
        default: if (pre_acc) begin
                  phase <= P_IDLE;
                  idx   <= idx + 1'b1;
                end
      endcase
      if (mode == M_SELF && lp_exit) idx <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_NORM;
    end else begin
      case (mode)
        M_NORM:  if (lp_req) mode <= M_DRAIN;
        M_DRAIN: if (phase == P_IDLE && idx == 5'd0) mode <= M_SELF;
        M_SELF:  if (lp_exit) mode <= M_BURST;
        default: if (pre_acc && idx == 5'd31) mode <= M_NORM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= SW'(T_RC);
      lastb <= '0;
    end else if (act_acc) begin
      since <= SW'(1);
      lastb <= cmd_bank;
    end else if (since < SW'(T_RC)) begin
      since <= since + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt      <= '0;
      burst_err <= 1'b0;
    end else begin
      if (mode != M_BURST) wcnt <= '0;
      else if (wcnt < WW'(T_BURST)) wcnt <= wcnt + 1'b1;
      if (mode == M_BURST && wcnt == WW'(T_BURST)) burst_err <= 1'b1;
    end
  end

  a_r3_held_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_bank) && $stable(cmd_pre));
  a_r3_gap_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    act_acc |=> !cmd_valid);
  a_r4_pre_on_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_pre |-> bank_locked[cmd_bank]);
  a_r11_one_open: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_pre |-> bank_locked == '0);
  a_r5_hold_refreshed: assert property (@(posedge clk) disable iff (!rst_n)
    act_acc |=> act_hold[$past(cmd_bank)]);
  a_r7_self_silent: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ack |-> !cmd_valid && !burst_active);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |=> burst_err);
endmodule

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  localparam int T_INT = 3, T_RAS = 4, T_RR = 2, T_RC = 7, T_BURST = 200, PEND_W = 3;
  localparam int PMAX = (1 << PEND_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, rdy = 1'b0, lpr = 1'b0, lpx = 1'b0;
  logic cmd_valid, cmd_pre, lp_ack, burst_active, burst_err;
  logic [4:0] cmd_bank;
  logic [1:0] cmd_sel;
  logic [31:0] bank_locked, act_hold;

  always #2.5 clk = ~clk;

  refresh_sched #(.T_INT(T_INT), .T_RAS(T_RAS), .T_RR(T_RR), .T_RC(T_RC),
                  .T_BURST(T_BURST), .PEND_W(PEND_W)) i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_ready(rdy), .lp_req(lpr), .lp_exit(lpx),
    .cmd_valid(cmd_valid), .cmd_pre(cmd_pre), .cmd_bank(cmd_bank), .cmd_sel(cmd_sel),
    .bank_locked(bank_locked), .act_hold(act_hold), .lp_ack(lp_ack),
    .burst_active(burst_active), .burst_err(burst_err));

  int seqtab[32] = '{12,10,5,3,0,14,9,7,4,2,13,11,8,6,1,15,
                     28,26,21,19,16,30,25,23,20,18,29,27,24,22,17,31};
  int checks = 0, fails = 0;
  int cyc, mmode, mstage, mpos, mpend, mtk, t_acc, mlast, wstart;
  bit merr, done = 0;

  function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; mmode = 0; mstage = 0; mpos = 0; mpend = 0; mtk = 0;
      t_acc = -1000; mlast = 0; wstart = 0; merr = 0;
      chk("R10", "cmd_valid", 32'(cmd_valid), 0);
      chk("R10", "status", {29'd0, lp_ack, burst_active, burst_err}, 0);
      chk("R10", "bank_locked", bank_locked, 0);
      chk("R10", "act_hold", act_hold, 0);
    end else if (!done) begin
      bit ev, acc;
      int d, nstage, npos, nmode;
      logic [31:0] elock, ehold;
      ev = (mstage == 1) || (mstage == 3);
      d = cyc - t_acc;
      elock = '0; ehold = '0;
      for (int b = 0; b < 32; b++) begin
        elock[b] = (mstage >= 2) && (seqtab[mpos] == b);
        ehold[b] = elock[b] || (d < T_RR) || (d < T_RC && (b - mlast <= 1) && (mlast - b <= 1));
      end
      chk("R2", "cmd_valid", 32'(cmd_valid), 32'(ev));
      chk("R1", "cmd_sel", 32'(cmd_sel), ev ? 3 : 0);
      if (ev) begin
        chk("R3", "cmd_pre", 32'(cmd_pre), 32'(mstage == 3));
        chk("R6", "cmd_bank", 32'(cmd_bank), seqtab[mpos]);
      end
      if (mstage == 1) chk("R11", "locked during activate", bank_locked, 0);
      chk("R4", "bank_locked", bank_locked, elock);
      chk("R5", "act_hold", act_hold, ehold);
      chk("R7", "lp_ack", 32'(lp_ack), 32'(mmode == 2));
      chk("R8", "burst_active", 32'(burst_active), 32'(mmode == 3));
      chk("R9", "burst_err", 32'(burst_err), 32'(merr));

      acc = ev && rdy;
      nstage = mstage; npos = mpos; nmode = mmode;
      if (mmode == 3 && cyc - wstart >= T_BURST) merr = 1;
      case (mstage)
        0: if ((mmode == 0 && mpend > 0) || (mmode == 1 && mpos != 0) || mmode == 3) nstage = 1;
        1: if (acc) begin nstage = 2; t_acc = cyc; mlast = seqtab[mpos]; end
        2: if (cyc + 1 == t_acc + T_RAS) nstage = 3;
        default: if (acc) begin nstage = 0; npos = (mpos + 1) % 32; end
      endcase
      case (mmode)
        0: if (lpr) nmode = 1;
        1: if (mstage == 0 && mpos == 0) nmode = 2;
        2: if (lpx) begin nmode = 3; wstart = cyc + 1; npos = 0; end
        default: if (mstage == 3 && acc && mpos == 31) nmode = 0;
      endcase
      if (mmode >= 2) begin
        mtk = 0; mpend = 0;
      end else begin
        bit due;
        due = tick && (mtk == T_INT - 1);
        if (tick) mtk = due ? 0 : mtk + 1;
        mpend = mpend + ((due && mpend < PMAX) ? 1 : 0) - ((mstage == 1 && acc && mpend > 0) ? 1 : 0);
      end
      mstage = nstage; mpos = npos; mmode = nmode;
      cyc++;
    end
  end

  task automatic drive(input bit t, input bit r, input bit q, input bit x);
    @(posedge clk); #1;
    tick = t; rdy = r; lpr = q; lpx = x;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2: saturating owed count, then paid off
    for (int i = 0; i < 60; i++) drive(1, 1, 0, 0);
    for (int i = 0; i < 120; i++) drive(0, 1, 0, 0);
    // R3: back-pressure on both command kinds
    for (int i = 0; i < 150; i++) drive(i % 2 == 0, i % 3 != 0, 0, 0);
    // R7: stray exit in normal mode is ignored
    drive(0, 1, 0, 1);
    for (int i = 0; i < 5; i++) drive(0, 1, 0, 0);
    // R7: drain to bank 31 and hand off
    drive(1, 1, 1, 0);
    for (int i = 0; i < 300; i++) drive(1, 1, 0, 0);
    drive(1, 1, 1, 0);
    for (int i = 0; i < 20; i++) drive(1, 1, 0, 0);
    // R8: clean burst inside the window
    drive(0, 1, 0, 1);
    for (int i = 0; i < 260; i++) drive(0, 1, 0, 0);
    drive(0, 1, 1, 0);
    for (int i = 0; i < 10; i++) drive(0, 1, 0, 0);
    // R9: throttled burst misses the window
    drive(0, 1, 0, 1);
    for (int i = 0; i < 500; i++) drive(0, i % 4 == 0, 0, 0);
    for (int i = 0; i < 20; i++) drive(0, 1, 0, 0);
    @(posedge clk);
    finish_run();
  end
endmodule